// File: doc/BRIEF.md
# SPI Low-Power Mode Sequencer

This block decides when an SPI controller may sleep. Two conditions can send it to sleep. The first is an external stop request, which ends in a clock-shutoff acknowledge. The second is a module-disable condition. Module disable is raised by a software disable bit, or by a hardware doze input while a doze-enable bit is set. Neither condition cuts a serial frame short. If a frame is active, the block waits for the shifter's frame-done pulse. If no frame is active, the boundary counts as reached at once, and the change takes effect on the next clock edge. When both requests are pending, external stop wins.

The block drives four things:
- a clock-enable for the controller's non-register logic;
- a stop acknowledge;
- a transfer-running status bit;
- an enable for each register side effect that the host bus can cause.

In external stop the register bus is dead, and the interrupt and DMA request lines are frozen. In module disable the registers stay readable. However, FIFO pops, pushes, clears, FIFO control changes, status-flag writes and transfer-count writes have no effect. Request lines may still be raised in this mode, but they cannot be cleared.

The state machine has five states:
- `ST_RUN`: normal operation.
- `ST_DRAIN_STOP`: a stop is pending and a frame is in progress.
- `ST_HALTED`: external stop.
- `ST_DRAIN_DIS`: a disable is pending and a frame is in progress.
- `ST_DORMANT`: module disable.

Transitions:
- RUN goes to HALTED or DORMANT when the boundary is reached, or to the matching DRAIN state while a frame is active. Stop is checked first.
- DRAIN_STOP goes to HALTED at the boundary, or back to RUN if the request is withdrawn.
- DRAIN_DIS goes to DRAIN_STOP or HALTED if a stop arrives, to DORMANT at the boundary, or back to RUN if the request is withdrawn.
- HALTED goes to RUN when the stop request drops.
- DORMANT goes to HALTED on a stop request, or to RUN once the disable bit and the effective doze are both low.

Top module: `spi_lp_ctrl`

## Requirements
- R1: After reset the block is in normal operation: clk_en=1, stop_ack=0, running=0, bus_ok=1.
- R2: A stop request while frame_active=0 gives stop_ack=1 and clk_en=0 after the next clock edge.
- R3: A stop request while frame_active=1 leaves clk_en=1 and stop_ack=0 until frame_done pulses. stop_ack rises on the edge that samples the pulse.
- R4: Module disable is requested when sw_dis=1, or when doze_in=1 and doze_en=1 together. doze_in with doze_en=0 has no effect.
- R5: A disable request negates clk_en at the frame boundary: on the next edge if frame_active=0, otherwise on the edge that samples frame_done. stop_ack stays 0 in disable.
- R6: running is cleared on entry to either low-power state. It is set by xfer_start only while clk_en=1, and xfer_start is ignored while clk_en=0.
- R7: In external stop, bus_ok=0 and every side-effect enable is 0. irq_out and dma_out hold the values they had before entry, whatever irq_in and dma_in do.
- R8: In module disable, bus_ok=1, but rx_pop_en, tx_push_en, fifo_clr_en, fifo_cfg_en, flag_wr_en and tcnt_wr_en are all 0 while their requests are 1. In normal operation each enable equals its request.
- R9: In module disable, a request line may rise but cannot fall. Each output bit is its held value ORed with its input.
- R10: Withdrawing the active request restores clk_en=1 after the next edge, with stop_ack=0 and running still 0.
- R11: External stop has priority. With both requests pending the block enters external stop, and a stop request during module disable moves it to external stop on the next edge.
- R12: Withdrawing a request while waiting for a frame boundary returns the block to normal operation without entering the low-power state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | External stop request level |
| sw_dis | input | 1 | Software module-disable bit |
| doze_in | input | 1 | Hardware doze signal |
| doze_en | input | 1 | Doze-enable control bit |
| frame_active | input | 1 | Shifter is inside a serial frame |
| frame_done | input | 1 | One-cycle pulse at the end of a frame |
| xfer_start | input | 1 | Pulse: a new transfer starts |
| bus_rx_pop | input | 1 | Bus read of the receive-pop register |
| bus_tx_push | input | 1 | Bus write of the transmit-push register |
| bus_fifo_clr | input | 1 | Bus FIFO clear command |
| bus_fifo_cfg | input | 1 | Bus write to the FIFO disable fields |
| bus_flag_wr | input | 1 | Bus write to status flags |
| bus_tcnt_wr | input | 1 | Bus write to the transfer-count register |
| irq_in | input | IRQ_W | Raw interrupt requests |
| dma_in | input | DMA_W | Raw DMA requests |
| clk_en | output | 1 | Clock enable for non-register logic |
| stop_ack | output | 1 | Clocks may be shut off |
| running | output | 1 | Transfer-running status bit |
| bus_ok | output | 1 | Register interface accessible |
| rx_pop_en | output | 1 | Receive FIFO may advance |
| tx_push_en | output | 1 | Transmit FIFO may accept data |
| fifo_clr_en | output | 1 | FIFO clear may act |
| fifo_cfg_en | output | 1 | FIFO disable fields may change |
| flag_wr_en | output | 1 | Status-flag write may act |
| tcnt_wr_en | output | 1 | Transfer-count write may act |
| irq_out | output | IRQ_W | Gated interrupt requests |
| dma_out | output | DMA_W | Gated DMA requests |

## Verification
Several properties are checked on every cycle:
- a frame in progress never loses its clock;
- stop_ack never coexists with clk_en, and running is low whenever clk_en is low;
- the side-effect enables are all low in either sleep state;
- the request lines are frozen in stop and never fall in disable;
- a pending stop with no active frame always leads to stop_ack;
- a withdrawn request always brings the clock back.

Other behaviours can only be shown by the bench's scenarios. These are the exact edge on which entry happens relative to the frame-done pulse, the sweep over all 32 request and frame combinations, the return to normal operation from a drain state, and the value that running keeps after exit.

// File: rtl/spi_lp_pkg.sv
package spi_lp_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_DRAIN_STOP,
        ST_HALTED,
        ST_DRAIN_DIS,
        ST_DORMANT
    } lp_state_t;
endpackage

// File: rtl/spi_lp_req.sv
module spi_lp_req (
    input  logic stop_req,
    input  logic sw_dis,
    input  logic doze_in,
    input  logic doze_en,
    input  logic frame_active,
    input  logic frame_done,
    output logic stop_pend,
    output logic dis_pend,
    output logic at_boundary
);
    always_comb begin
        stop_pend   = stop_req;
        dis_pend    = sw_dis | (doze_in & doze_en);
        // With no frame in flight the boundary is already reached.
        at_boundary = ~frame_active | frame_done;
    end
endmodule

// File: rtl/spi_lp_fsm.sv
module spi_lp_fsm
    import spi_lp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_pend,
    input  logic      dis_pend,
    input  logic      at_boundary,
    input  logic      xfer_start,
    output lp_state_t state,
    output logic      clk_en,
    output logic      stop_ack,
    output logic      running
);
    lp_state_t nxt;
    logic      nxt_clk_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (stop_pend)     nxt = at_boundary ? ST_HALTED  : ST_DRAIN_STOP;
                else if (dis_pend) nxt = at_boundary ? ST_DORMANT : ST_DRAIN_DIS;
            end
            ST_DRAIN_STOP: begin
                if (!stop_pend)       nxt = ST_RUN;
                else if (at_boundary) nxt = ST_HALTED;
            end
            ST_DRAIN_DIS: begin
                if (stop_pend)        nxt = at_boundary ? ST_HALTED : ST_DRAIN_STOP;
                else if (!dis_pend)   nxt = ST_RUN;
                else if (at_boundary) nxt = ST_DORMANT;
            end
            ST_HALTED: begin
                if (!stop_pend) nxt = ST_RUN;
            end
            ST_DORMANT: begin
                if (stop_pend)      nxt = ST_HALTED;
                else if (!dis_pend) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_comb begin
        clk_en     = (state != ST_HALTED) && (state != ST_DORMANT);
        stop_ack   = (state == ST_HALTED);
        nxt_clk_en = (nxt != ST_HALTED) && (nxt != ST_DORMANT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   running <= 1'b0;
        else if (!nxt_clk_en)         running <= 1'b0;
        else if (xfer_start && clk_en) running <= 1'b1;
    end
endmodule

// File: rtl/spi_lp_gate.sv
module spi_lp_gate
    import spi_lp_pkg::*;
#(
    parameter int IRQ_W = 1,
    parameter int DMA_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lp_state_t        state,
    input  logic             bus_rx_pop,
    input  logic             bus_tx_push,
    input  logic             bus_fifo_clr,
    input  logic             bus_fifo_cfg,
    input  logic             bus_flag_wr,
    input  logic             bus_tcnt_wr,
    input  logic [IRQ_W-1:0] irq_in,
    input  logic [DMA_W-1:0] dma_in,
    output logic             bus_ok,
    output logic             rx_pop_en,
    output logic             tx_push_en,
    output logic             fifo_clr_en,
    output logic             fifo_cfg_en,
    output logic             flag_wr_en,
    output logic             tcnt_wr_en,
    output logic [IRQ_W-1:0] irq_out,
    output logic [DMA_W-1:0] dma_out
);
    localparam int NCH = IRQ_W + DMA_W;

    logic           awake;
    logic [NCH-1:0] req_in, req_out;

    always_comb begin
        awake       = (state != ST_HALTED) && (state != ST_DORMANT);
        bus_ok      = (state != ST_HALTED);
        rx_pop_en   = bus_rx_pop   & awake;
        tx_push_en  = bus_tx_push  & awake;
        fifo_clr_en = bus_fifo_clr & awake;
        fifo_cfg_en = bus_fifo_cfg & awake;
        flag_wr_en  = bus_flag_wr  & awake;
        tcnt_wr_en  = bus_tcnt_wr  & awake;
        req_in      = {dma_in, irq_in};
    end

    for (genvar g = 0; g < NCH; g++) begin : g_hold
        logic held;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held <= 1'b0;
            else        held <= req_out[g];
        end
        always_comb begin
            unique case (state)
                ST_HALTED:  req_out[g] = held;
                ST_DORMANT: req_out[g] = held | req_in[g];
                default:    req_out[g] = req_in[g];
            endcase
        end
    end

    assign irq_out = req_out[IRQ_W-1:0];
    assign dma_out = req_out[NCH-1:IRQ_W];
endmodule

// File: rtl/spi_lp_ctrl.sv
module spi_lp_ctrl
    import spi_lp_pkg::*;
#(
    parameter int IRQ_W = 1,
    parameter int DMA_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             sw_dis,
    input  logic             doze_in,
    input  logic             doze_en,
    input  logic             frame_active,
    input  logic             frame_done,
    input  logic             xfer_start,
    input  logic             bus_rx_pop,
    input  logic             bus_tx_push,
    input  logic             bus_fifo_clr,
    input  logic             bus_fifo_cfg,
    input  logic             bus_flag_wr,
    input  logic             bus_tcnt_wr,
    input  logic [IRQ_W-1:0] irq_in,
    input  logic [DMA_W-1:0] dma_in,
    output logic             clk_en,
    output logic             stop_ack,
    output logic             running,
    output logic             bus_ok,
    output logic             rx_pop_en,
    output logic             tx_push_en,
    output logic             fifo_clr_en,
    output logic             fifo_cfg_en,
    output logic             flag_wr_en,
    output logic             tcnt_wr_en,
    output logic [IRQ_W-1:0] irq_out,
    output logic [DMA_W-1:0] dma_out
);
    logic      stop_pend, dis_pend, at_boundary;
    lp_state_t state;

    spi_lp_req req_i (
        .stop_req     (stop_req),
        .sw_dis       (sw_dis),
        .doze_in      (doze_in),
        .doze_en      (doze_en),
        .frame_active (frame_active),
        .frame_done   (frame_done),
        .stop_pend    (stop_pend),
        .dis_pend     (dis_pend),
        .at_boundary  (at_boundary)
    );

    spi_lp_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_pend   (stop_pend),
        .dis_pend    (dis_pend),
        .at_boundary (at_boundary),
        .xfer_start  (xfer_start),
        .state       (state),
        .clk_en      (clk_en),
        .stop_ack    (stop_ack),
        .running     (running)
    );

    spi_lp_gate #(.IRQ_W(IRQ_W), .DMA_W(DMA_W)) gate_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .bus_rx_pop   (bus_rx_pop),
        .bus_tx_push  (bus_tx_push),
        .bus_fifo_clr (bus_fifo_clr),
        .bus_fifo_cfg (bus_fifo_cfg),
        .bus_flag_wr  (bus_flag_wr),
        .bus_tcnt_wr  (bus_tcnt_wr),
        .irq_in       (irq_in),
        .dma_in       (dma_in),
        .bus_ok       (bus_ok),
        .rx_pop_en    (rx_pop_en),
        .tx_push_en   (tx_push_en),
        .fifo_clr_en  (fifo_clr_en),
        .fifo_cfg_en  (fifo_cfg_en),
        .flag_wr_en   (flag_wr_en),
        .tcnt_wr_en   (tcnt_wr_en),
        .irq_out      (irq_out),
        .dma_out      (dma_out)
    );
endmodule

// File: rtl/spi_lp_ctrl_chk.sv
module spi_lp_ctrl_chk #(
    parameter int IRQ_W = 1,
    parameter int DMA_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_req,
    input logic             sw_dis,
    input logic             doze_in,
    input logic             doze_en,
    input logic             frame_active,
    input logic             frame_done,
    input logic             xfer_start,
    input logic             bus_rx_pop,
    input logic             bus_tx_push,
    input logic             bus_fifo_clr,
    input logic             bus_fifo_cfg,
    input logic             bus_flag_wr,
    input logic             bus_tcnt_wr,
    input logic [IRQ_W-1:0] irq_in,
    input logic [DMA_W-1:0] dma_in,
    input logic             clk_en,
    input logic             stop_ack,
    input logic             running,
    input logic             bus_ok,
    input logic             rx_pop_en,
    input logic             tx_push_en,
    input logic             fifo_clr_en,
    input logic             fifo_cfg_en,
    input logic             flag_wr_en,
    input logic             tcnt_wr_en,
    input logic [IRQ_W-1:0] irq_out,
    input logic [DMA_W-1:0] dma_out
);
    logic any_en, dormant, want_dis, bus_any;
    assign any_en   = rx_pop_en | tx_push_en | fifo_clr_en | fifo_cfg_en | flag_wr_en | tcnt_wr_en;
    assign bus_any  = bus_rx_pop | bus_tx_push | bus_fifo_clr | bus_fifo_cfg | bus_flag_wr | bus_tcnt_wr;
    assign dormant  = !clk_en && bus_ok;
    assign want_dis = sw_dis || (doze_in && doze_en);

    // R2: clocks may only be shut off with the clock enable low.
    p_ack_no_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ack |-> !clk_en);

    // R3, R5: a frame still in flight never loses its clock.
    p_frame_keeps_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && frame_active && !frame_done) |=> clk_en);

    // R6: the running status is never set while asleep.
    p_run_low_asleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> !running);

    // R7: bus dead and no side effects in external stop.
    p_stop_bus_dead_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ack |-> (!bus_ok && !any_en));

    // R7: request lines frozen in external stop.
    p_stop_req_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ack && $past(stop_ack)) |-> ($stable(irq_out) && $stable(dma_out)));

    // R8: no side effects in module disable even when requested.
    p_dis_no_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dormant && bus_any) |-> !any_en);

    // R9: request lines never fall while in module disable.
    p_dis_no_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dormant && $past(dormant)) |->
        (((irq_out & $past(irq_out)) == $past(irq_out)) && ((dma_out & $past(dma_out)) == $past(dma_out))));

    // R10: a withdrawn request always restores the clock.
    p_exit_restores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !stop_req && !want_dis) |=> (clk_en && !stop_ack));

    // R11: a pending stop at a free boundary always ends in the acknowledge.
    p_stop_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !frame_active && clk_en && !xfer_start) |=> stop_ack);
endmodule

bind spi_lp_ctrl spi_lp_ctrl_chk #(.IRQ_W(IRQ_W), .DMA_W(DMA_W)) chk_i (.*);

// File: tb/spi_lp_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_lp_ctrl_tb_top;
    localparam int IRQ_W = 1;
    localparam int DMA_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, sw_dis = 0, doze_in = 0, doze_en = 0;
    logic frame_active = 0, frame_done = 0, xfer_start = 0;
    logic bus_rx_pop = 0, bus_tx_push = 0, bus_fifo_clr = 0;
    logic bus_fifo_cfg = 0, bus_flag_wr = 0, bus_tcnt_wr = 0;
    logic [IRQ_W-1:0] irq_in = '0;
    logic [DMA_W-1:0] dma_in = '0;
    logic clk_en, stop_ack, running, bus_ok;
    logic rx_pop_en, tx_push_en, fifo_clr_en, fifo_cfg_en, flag_wr_en, tcnt_wr_en;
    logic [IRQ_W-1:0] irq_out;
    logic [DMA_W-1:0] dma_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    spi_lp_ctrl #(.IRQ_W(IRQ_W), .DMA_W(DMA_W)) dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_bus(input logic v);
        bus_rx_pop = v; bus_tx_push = v; bus_fifo_clr = v;
        bus_fifo_cfg = v; bus_flag_wr = v; bus_tcnt_wr = v;
    endtask

    task automatic clear_all();
        stop_req = 0; sw_dis = 0; doze_in = 0; doze_en = 0;
        frame_active = 0; frame_done = 0; xfer_start = 0;
        set_bus(1'b0);
    endtask

    function automatic int en_vec();
        return {rx_pop_en, tx_push_en, fifo_clr_en, fifo_cfg_en, flag_wr_en, tcnt_wr_en};
    endfunction

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk("R1 clk_en", clk_en, 1);
        chk("R1 stop_ack", stop_ack, 0);
        chk("R1 running", running, 0);
        chk("R1 bus_ok", bus_ok, 1);

        // Sweep every combination of requests and frame state from normal operation.
        for (int i = 0; i < 32; i++) begin
            logic s, sw, dz, de, fa, dis, asleep;
            s = i[0]; sw = i[1]; dz = i[2]; de = i[3]; fa = i[4];
            dis = sw | (dz & de);            // R4 decode
            asleep = s | dis;
            clear_all();
            xfer_start = 1; tick(); xfer_start = 0;
            chk("R6 running set", running, 1);
            stop_req = s; sw_dis = sw; doze_in = dz; doze_en = de; frame_active = fa;
            if (fa) begin
                tick();
                // R3 R5: still awake mid-frame
                chk("R3 wait clk_en", clk_en, 1);
                chk("R3 wait ack", stop_ack, 0);
                frame_done = 1; tick();
                frame_done = 0; frame_active = 0;
            end else begin
                tick();
            end
            chk("R2 ack", stop_ack, s);
            chk("R4 R5 clk_en", clk_en, asleep ? 0 : 1);
            chk("R6 running", running, asleep ? 0 : 1);
            chk("R11 prio", stop_ack, (s & dis) ? 1 : s);
            // R7 R8: side-effect gating
            set_bus(1'b1); xfer_start = 1; #1;
            chk("R7 R8 bus_ok", bus_ok, s ? 0 : 1);
            chk("R8 enables", en_vec(), asleep ? 0 : 63);
            tick();
            chk("R6 start ignored", running, asleep ? 0 : 1);
            set_bus(1'b0); xfer_start = 0;
            stop_req = 0; sw_dis = 0; doze_in = 0;
            tick();
            // R10: exit
            chk("R10 clk_en", clk_en, 1);
            chk("R10 ack", stop_ack, 0);
            chk("R10 running", running, asleep ? 0 : 1);
        end

        // R12: withdraw stop while draining
        clear_all(); tick();
        stop_req = 1; frame_active = 1; tick();
        stop_req = 0; tick();
        chk("R12 clk_en", clk_en, 1);
        frame_done = 1; tick(); frame_done = 0; frame_active = 0; tick();
        chk("R12 no ack", stop_ack, 0);
        chk("R12 clk_en after", clk_en, 1);

        // R12: withdraw disable while draining
        sw_dis = 1; frame_active = 1; tick();
        sw_dis = 0; tick();
        frame_done = 1; tick(); frame_done = 0; frame_active = 0; tick();
        chk("R12 dis clk_en", clk_en, 1);

        // R11: stop during module disable
        sw_dis = 1; tick();
        chk("R11 dormant", clk_en, 0);
        stop_req = 1; tick();
        chk("R11 stop wins", stop_ack, 1);
        stop_req = 0; tick();
        chk("R11 back to dormant-capable", stop_ack, 0);
        sw_dis = 0; tick();
        chk("R11 exit", clk_en, 1);

        // R11: stop pending while draining a disable
        sw_dis = 1; frame_active = 1; tick();
        stop_req = 1; frame_done = 1; tick();
        frame_done = 0; frame_active = 0;
        chk("R11 drain redirect", stop_ack, 1);
        clear_all(); tick();

        // R7: request lines frozen in stop
        irq_in = 1'b0; dma_in = 2'b01; tick();
        stop_req = 1; tick();
        chk("R7 stop entered", stop_ack, 1);
        irq_in = 1'b1; dma_in = 2'b10; #1;
        chk("R7 irq frozen", irq_out, 0);
        chk("R7 dma frozen", dma_out, 1);
        tick();
        chk("R7 dma frozen 2", dma_out, 1);
        clear_all(); irq_in = 0; dma_in = 0; tick();
        chk("R7 follows after exit", dma_out, 0);

        // R9: set allowed, clear blocked in disable
        sw_dis = 1; tick();
        irq_in = 1'b1; dma_in = 2'b10; #1;
        chk("R9 irq set", irq_out, 1);
        tick();
        irq_in = 1'b0; dma_in = 2'b00; #1;
        chk("R9 irq held", irq_out, 1);
        chk("R9 dma held", dma_out, 2);
        tick();
        dma_in = 2'b01; #1;
        chk("R9 dma or", dma_out, 3);
        tick();
        dma_in = 2'b00;
        sw_dis = 0; tick();
        chk("R9 released", dma_out, 0);
        chk("R9 irq released", irq_out, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule